// File: doc/BRIEF.md
# Early-Terminating Iterative Multiplier

This block multiplies a 32-bit multiplicand by a 32-bit multiplier over several clock cycles. It stops as soon as the remaining high part of the multiplier carries no further information. Each iteration folds one 12-bit slice of the multiplier magnitude into a running 64-bit sum. Small multipliers therefore finish in one pass, and full-width ones need three. The block has a short form, which gives a 32-bit result with optional 32-bit accumulate. It also has long forms, which give a 64-bit signed or unsigned result with optional 64-bit accumulate.

The total busy time is the pass count plus fixed penalties. A long form adds one cycle. A request to update the negative/zero flags adds two. A dependency hint adds one stall cycle when the next operation needs this result. The stall is waived when a long operation's high word feeds the next long multiply only as its multiplier. The block reports the cycles it took next to the exact product. The product, the count and the flags stay on the outputs until the next accepted start.

Top module: `etmul_core`

## Requirements
- R1: Opcode 0 yields the low 32 bits of opa*opb and opcode 1 adds acc_lo to that. Opcodes 6 and 7 behave as opcode 0. For all short forms res_hi is 0.
- R2: Opcode 2 is the unsigned 64-bit product, opcode 3 adds {acc_hi,acc_lo} to it modulo 2^64, opcode 4 is the signed 64-bit product and opcode 5 adds {acc_hi,acc_lo} to that. The result is {res_hi,res_lo}.
- R3: The pass count is 1 when the multiplier magnitude is at most 0x7FF, 2 when it is at most 0x7FFFFF, and 3 otherwise. The magnitude is the absolute value of opb read as signed for opcodes 0, 1 and 4 to 7, and opb read as unsigned for opcodes 2 and 3. 0x80000000 falls in the 3-pass band.
- R4: The long forms (opcodes 2 to 5) take one cycle more than a short form in the same band.
- R5: A start with set_flags high adds 2 cycles and loads flag_n with the result's top bit (bit 31 short, bit 63 long) and flag_z with result==0. Without set_flags both flags keep their values.
- R6: nxt_dep high adds 1 stall cycle, except when the operation is a long form and nxt_hi_mult is also high.
- R7: busy stays high for exactly `cycles` clock cycles after the start edge. done pulses for one cycle as busy falls. res_lo, res_hi and cycles stay unchanged while idle until the next start.
- R8: A start raised while busy is ignored: it neither changes the running operation's result or count nor starts a further one.
- R9: After reset busy, done, res_lo, res_hi, cycles, flag_n and flag_z are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation with the operands on this cycle (idle only) |
| op | input | 3 | Variant: 0 mul, 1 mul-acc, 2 unsigned long, 3 unsigned long acc, 4 signed long, 5 signed long acc |
| set_flags | input | 1 | Update flag_n/flag_z, adds 2 cycles |
| nxt_dep | input | 1 | The next operation consumes this result |
| nxt_hi_mult | input | 1 | The next operation is a long multiply using the high word only as multiplier |
| opa | input | 32 | Multiplicand |
| opb | input | 32 | Multiplier (decides the latency) |
| acc_lo | input | 32 | Accumulate addend, low word |
| acc_hi | input | 32 | Accumulate addend, high word (long forms) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| res_lo | output | 32 | Result low word |
| res_hi | output | 32 | Result high word (0 for short forms) |
| cycles | output | 4 | Cycles taken by the last operation |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |

## Verification
The bench builds the block with its default parameters: a 32-bit datapath and 12-bit slices. That gives three slices, so every magnitude band and both edges of each band (0x7FF/0x800 and 0x7FFFFF/0x800000) can be reached with plain operands. Negative multipliers just inside and just outside each band show that classification uses the absolute value. The combined case of long form, flag request and dependency reaches the largest count of 7.

// File: rtl/etmul_pkg.sv
package etmul_pkg;

    localparam int XLEN    = 32;
    localparam int SLICE_W = 12;
    localparam int CYC_W   = 4;
    localparam int PEN_W   = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ITER = 2'd1,
        ST_PEN  = 2'd2
    } state_e;

    typedef struct packed {
        logic is_long;
        logic is_signed;
        logic accum;
    } mode_t;

    // Opcode decode; unlisted codes fall back to the plain short multiply.
    function automatic mode_t decode_op(input logic [2:0] op);
        mode_t m;
        m = '{is_long: 1'b0, is_signed: 1'b1, accum: 1'b0};
        case (op)
            3'd1: m.accum = 1'b1;
            3'd2: begin m.is_long = 1'b1; m.is_signed = 1'b0; end
            3'd3: begin m.is_long = 1'b1; m.is_signed = 1'b0; m.accum = 1'b1; end
            3'd4: m.is_long = 1'b1;
            3'd5: begin m.is_long = 1'b1; m.accum = 1'b1; end
            default: ;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/etmul_prep.sv
module etmul_prep
    import etmul_pkg::*;
#(
    parameter int W     = XLEN,
    parameter int PEN_B = PEN_W
) (
    input  logic [2:0]       op,
    input  logic             set_flags,
    input  logic             nxt_dep,
    input  logic             nxt_hi_mult,
    input  logic [W-1:0]     opa,
    input  logic [W-1:0]     opb,
    output mode_t            mode,
    output logic [W-1:0]     mag,
    output logic             neg,
    output logic [2*W-1:0]   a_ext,
    output logic [PEN_B-1:0] penalty
);
    logic stall;

    always_comb begin
        mode  = decode_op(op);
        neg   = mode.is_signed & opb[W-1];
        mag   = neg ? (~opb + W'(1)) : opb;
        a_ext = mode.is_signed ? {{W{opa[W-1]}}, opa} : {{W{1'b0}}, opa};
        stall = nxt_dep & ~(mode.is_long & nxt_hi_mult);
        penalty = PEN_B'(mode.is_long) + (set_flags ? PEN_B'(2) : PEN_B'(0))
                + PEN_B'(stall);
    end
endmodule

// File: rtl/etmul_step.sv
module etmul_step #(
    parameter int W    = 32,
    parameter int SW   = 12,
    parameter int NS   = 3,
    parameter int KW   = 2
) (
    input  logic [2*W-1:0] acc,
    input  logic [2*W-1:0] a_ext,
    input  logic [W-1:0]   mag,
    input  logic [KW-1:0]  k,
    output logic [2*W-1:0] acc_nxt,
    output logic           last
);
    localparam int PADW = NS * SW;

    logic [PADW-1:0] mag_pad;
    logic [SW-1:0]   slice;
    logic [2*W-1:0]  pp;
    int              sh;

    always_comb begin
        mag_pad = '0;
        mag_pad[W-1:0] = mag;
        slice   = mag_pad[int'(k)*SW +: SW];
        pp      = a_ext * {{(2*W-SW){1'b0}}, slice};
        acc_nxt = acc + (pp << (int'(k) * SW));
        // Done when the magnitude fits one bit below the span retired so far.
        sh      = SW * (int'(k) + 1) - 1;
        last    = ((mag >> sh) == '0) || (k == KW'(NS - 1));
    end
endmodule

// File: rtl/etmul_finish.sv
module etmul_finish
    import etmul_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [2*W-1:0] sum_raw,
    input  logic           neg,
    input  mode_t          mode,
    input  logic [W-1:0]   add_lo,
    input  logic [W-1:0]   add_hi,
    output logic [W-1:0]   res_lo,
    output logic [W-1:0]   res_hi,
    output logic           fn,
    output logic           fz
);
    logic [2*W-1:0] prod;
    logic [2*W-1:0] addend;
    logic [2*W-1:0] total;

    always_comb begin
        prod = neg ? (~sum_raw + (2*W)'(1)) : sum_raw;
        if (!mode.accum)
            addend = '0;
        else if (mode.is_long)
            addend = {add_hi, add_lo};
        else
            addend = {{W{1'b0}}, add_lo};
        total  = prod + addend;
        res_lo = total[W-1:0];
        res_hi = mode.is_long ? total[2*W-1:W] : '0;
        fn     = mode.is_long ? total[2*W-1] : total[W-1];
        fz     = mode.is_long ? (total == '0) : (total[W-1:0] == '0);
    end
endmodule

// File: rtl/etmul_core.sv
module etmul_core
    import etmul_pkg::*;
#(
    parameter int W     = XLEN,
    parameter int SW    = SLICE_W,
    parameter int CW    = CYC_W,
    parameter int PEN_B = PEN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [2:0]    op,
    input  logic          set_flags,
    input  logic          nxt_dep,
    input  logic          nxt_hi_mult,
    input  logic [W-1:0]  opa,
    input  logic [W-1:0]  opb,
    input  logic [W-1:0]  acc_lo,
    input  logic [W-1:0]  acc_hi,
    output logic          busy,
    output logic          done,
    output logic [W-1:0]  res_lo,
    output logic [W-1:0]  res_hi,
    output logic [CW-1:0] cycles,
    output logic          flag_n,
    output logic          flag_z
);
    localparam int NS = (W + SW - 1) / SW;
    localparam int KW = $clog2(NS + 1);

    state_e             state;
    mode_t              mode_d, mode_q;
    logic [W-1:0]       mag_d, mag_q;
    logic               neg_d, neg_q;
    logic [2*W-1:0]     aext_d, aext_q;
    logic [PEN_B-1:0]   pen_d, pen_q;
    logic               flags_q;
    logic [W-1:0]       add_lo_q, add_hi_q;
    logic [2*W-1:0]     acc_q, acc_nxt;
    logic [KW-1:0]      k_q;
    logic [CW-1:0]      cyc_q;
    logic               last;
    logic [W-1:0]       fin_lo, fin_hi;
    logic               fin_n, fin_z;

    etmul_prep #(.W(W), .PEN_B(PEN_B)) prep_i (
        .op(op), .set_flags(set_flags), .nxt_dep(nxt_dep), .nxt_hi_mult(nxt_hi_mult),
        .opa(opa), .opb(opb), .mode(mode_d), .mag(mag_d), .neg(neg_d),
        .a_ext(aext_d), .penalty(pen_d)
    );

    etmul_step #(.W(W), .SW(SW), .NS(NS), .KW(KW)) step_i (
        .acc(acc_q), .a_ext(aext_q), .mag(mag_q), .k(k_q),
        .acc_nxt(acc_nxt), .last(last)
    );

    etmul_finish #(.W(W)) fin_i (
        .sum_raw(acc_nxt), .neg(neg_q), .mode(mode_q), .add_lo(add_lo_q),
        .add_hi(add_hi_q), .res_lo(fin_lo), .res_hi(fin_hi), .fn(fin_n), .fz(fin_z)
    );

    assign busy = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            mode_q   <= '0;
            mag_q    <= '0;
            neg_q    <= 1'b0;
            aext_q   <= '0;
            pen_q    <= '0;
            flags_q  <= 1'b0;
            add_lo_q <= '0;
            add_hi_q <= '0;
            acc_q    <= '0;
            k_q      <= '0;
            cyc_q    <= '0;
            done     <= 1'b0;
            res_lo   <= '0;
            res_hi   <= '0;
            cycles   <= '0;
            flag_n   <= 1'b0;
            flag_z   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        mode_q   <= mode_d;
                        mag_q    <= mag_d;
                        neg_q    <= neg_d;
                        aext_q   <= aext_d;
                        pen_q    <= pen_d;
                        flags_q  <= set_flags;
                        add_lo_q <= acc_lo;
                        add_hi_q <= acc_hi;
                        acc_q    <= '0;
                        k_q      <= '0;
                        cyc_q    <= CW'(1);
                        state    <= ST_ITER;
                    end
                end
                ST_ITER: begin
                    if (last) begin
                        res_lo <= fin_lo;
                        res_hi <= fin_hi;
                        if (flags_q) begin
                            flag_n <= fin_n;
                            flag_z <= fin_z;
                        end
                        if (pen_q == '0) begin
                            state  <= ST_IDLE;
                            done   <= 1'b1;
                            cycles <= cyc_q;
                        end else begin
                            state <= ST_PEN;
                            cyc_q <= cyc_q + CW'(1);
                        end
                    end else begin
                        acc_q <= acc_nxt;
                        k_q   <= k_q + KW'(1);
                        cyc_q <= cyc_q + CW'(1);
                    end
                end
                ST_PEN: begin
                    if (pen_q == PEN_B'(1)) begin
                        state  <= ST_IDLE;
                        done   <= 1'b1;
                        cycles <= cyc_q;
                    end else begin
                        pen_q <= pen_q - PEN_B'(1);
                        cyc_q <= cyc_q + CW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/etmul_core_chk.sv
module etmul_core_chk #(
    parameter int W  = 32,
    parameter int SW = 12,
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic [2:0]    op,
    input logic          set_flags,
    input logic          busy,
    input logic          done,
    input logic [W-1:0]  res_lo,
    input logic [W-1:0]  res_hi,
    input logic [CW-1:0] cycles
);
    localparam int NS     = (W + SW - 1) / SW;
    localparam int CYCMAX = NS + 4;

    logic [CW-1:0] busy_cnt;
    logic          long_q;
    logic          flg_q;

    always_ff @(posedge clk) begin
        if (rst || !busy) busy_cnt <= '0;
        else              busy_cnt <= busy_cnt + CW'(1);
        if (rst) begin
            long_q <= 1'b0;
            flg_q  <= 1'b0;
        end else if (start && !busy) begin
            long_q <= (op >= 3'd2) && (op <= 3'd5);
            flg_q  <= set_flags;
        end
    end

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_busy_fall_done_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    p_count_matches_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (cycles == busy_cnt));

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(res_lo) && $stable(res_hi) && $stable(cycles)));

    p_short_hi_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (done && !long_q) |-> (res_hi == '0));

    p_long_extra_r4: assert property (@(posedge clk) disable iff (rst)
        (done && long_q) |-> (cycles >= CW'(2)));

    p_flag_penalty_r5: assert property (@(posedge clk) disable iff (rst)
        (done && flg_q) |-> (cycles >= CW'(3)));

    p_band_bound_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> ((cycles >= CW'(1)) && (cycles <= CW'(CYCMAX))));
endmodule

bind etmul_core etmul_core_chk #(.W(W), .SW(SW), .CW(CW)) chk_i (
    .clk(clk), .rst(rst), .start(start), .op(op), .set_flags(set_flags),
    .busy(busy), .done(done), .res_lo(res_lo), .res_hi(res_hi), .cycles(cycles)
);

// File: tb/etmul_core_tb_top.sv
module etmul_core_tb_top;

    typedef struct packed {
        logic [2:0]  op;
        logic        fl;
        logic        dep;
        logic        him;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] ahi;
        logic [31:0] alo;
        logic [3:0]  ecyc;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b0, 1'b0, 1'b0, 32'd3,        32'd5,        32'd0, 32'd0, 4'd1},
        '{3'd0, 1'b0, 1'b0, 1'b0, 32'd7,        32'h7FF,      32'd0, 32'd0, 4'd1},
        '{3'd0, 1'b0, 1'b0, 1'b0, 32'd7,        32'h800,      32'd0, 32'd0, 4'd2},
        '{3'd0, 1'b0, 1'b0, 1'b0, 32'd9,        32'hFFFFF801, 32'd0, 32'd0, 4'd1},
        '{3'd0, 1'b0, 1'b0, 1'b0, 32'd9,        32'hFFFFF800, 32'd0, 32'd0, 4'd2},
        '{3'd0, 1'b0, 1'b0, 1'b0, 32'h1234,     32'h7FFFFF,   32'd0, 32'd0, 4'd2},
        '{3'd0, 1'b0, 1'b0, 1'b0, 32'h1234,     32'h800000,   32'd0, 32'd0, 4'd3},
        '{3'd0, 1'b0, 1'b0, 1'b0, 32'h10001,    32'h80000000, 32'd0, 32'd0, 4'd3},
        '{3'd1, 1'b0, 1'b0, 1'b0, 32'h12345678, 32'h9ABC,     32'd0, 32'h11111111, 4'd2},
        '{3'd2, 1'b0, 1'b0, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'd0, 32'd0, 4'd4},
        '{3'd2, 1'b0, 1'b0, 1'b0, 32'hDEADBEEF, 32'h7FF,      32'd0, 32'd0, 4'd2},
        '{3'd4, 1'b0, 1'b0, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFE, 32'd0, 32'd0, 4'd2},
        '{3'd5, 1'b0, 1'b0, 1'b0, 32'h80000000, 32'h80000000, 32'd0, 32'd1, 4'd4},
        '{3'd0, 1'b1, 1'b0, 1'b0, 32'd0,        32'd5,        32'd0, 32'd0, 4'd3},
        '{3'd4, 1'b1, 1'b0, 1'b0, 32'hFFFFFFFF, 32'd1,        32'd0, 32'd0, 4'd4},
        '{3'd0, 1'b0, 1'b1, 1'b0, 32'd3,        32'd3,        32'd0, 32'd0, 4'd2},
        '{3'd2, 1'b0, 1'b1, 1'b1, 32'd3,        32'd3,        32'd0, 32'd0, 4'd2},
        '{3'd0, 1'b0, 1'b1, 1'b1, 32'd3,        32'd3,        32'd0, 32'd0, 4'd2},
        '{3'd5, 1'b1, 1'b1, 1'b0, 32'd7,        32'h800000,   32'd0, 32'd0, 4'd7},
        '{3'd3, 1'b0, 1'b0, 1'b0, 32'h10000,    32'h10000,    32'hFFFFFFFF, 32'hFFFFFFFF, 4'd3},
        '{3'd7, 1'b0, 1'b0, 1'b0, 32'd3,        32'd3,        32'd0, 32'd0, 4'd1},
        '{3'd2, 1'b0, 1'b1, 1'b0, 32'd5,        32'd5,        32'd0, 32'd0, 4'd3},
        '{3'd4, 1'b0, 1'b0, 1'b0, 32'h7FFFFFFF, 32'hFF800000, 32'd0, 32'd0, 4'd4},
        '{3'd4, 1'b0, 1'b0, 1'b0, 32'd5,        32'hFF800001, 32'd0, 32'd0, 4'd3}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [2:0]  op;
    logic        set_flags, nxt_dep, nxt_hi_mult;
    logic [31:0] opa, opb, acc_lo, acc_hi;
    logic        busy, done, flag_n, flag_z;
    logic [31:0] res_lo, res_hi;
    logic [3:0]  cycles;

    int n_checks = 0;
    int n_errors = 0;
    logic mn = 1'b0;
    logic mz = 1'b0;

    always #4 clk = ~clk;

    etmul_core dut_i (
        .clk(clk), .rst(rst), .start(start), .op(op), .set_flags(set_flags),
        .nxt_dep(nxt_dep), .nxt_hi_mult(nxt_hi_mult), .opa(opa), .opb(opb),
        .acc_lo(acc_lo), .acc_hi(acc_hi), .busy(busy), .done(done),
        .res_lo(res_lo), .res_hi(res_hi), .cycles(cycles),
        .flag_n(flag_n), .flag_z(flag_z)
    );

    task automatic check(input bit ok, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    function automatic logic [63:0] model(input vec_t v);
        logic [63:0] p;
        case (v.op)
            3'd2, 3'd3: p = {32'd0, v.a} * {32'd0, v.b};
            3'd4, 3'd5: p = {{32{v.a[31]}}, v.a} * {{32{v.b[31]}}, v.b};
            default:    p = {32'd0, v.a * v.b};
        endcase
        if (v.op == 3'd1) p = {32'd0, p[31:0] + v.alo};
        if (v.op == 3'd3 || v.op == 3'd5) p = p + {v.ahi, v.alo};
        return p;
    endfunction

    task automatic issue(input vec_t v);
        @(negedge clk);
        op = v.op; set_flags = v.fl; nxt_dep = v.dep; nxt_hi_mult = v.him;
        opa = v.a; opb = v.b; acc_hi = v.ahi; acc_lo = v.alo;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int bc, output bit ok);
        int guard = 0;
        bc = 0;
        while (!done && guard < 100) begin
            if (busy) bc++;
            @(negedge clk);
            guard++;
        end
        ok = done;
    endtask

    initial begin
        #(8 * 200000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; op = '0; set_flags = 1'b0; nxt_dep = 1'b0;
        nxt_hi_mult = 1'b0; opa = '0; opb = '0; acc_lo = '0; acc_hi = '0;
        repeat (4) @(negedge clk);
        // R9 reset state
        check(!busy && !done, "R9 busy/done after reset", {62'd0, busy, done}, 64'd0);
        check(res_lo == 0 && res_hi == 0, "R9 result after reset", {res_hi, res_lo}, 64'd0);
        check(cycles == 0 && !flag_n && !flag_z, "R9 cycles/flags after reset",
              {58'd0, cycles, flag_n, flag_z}, 64'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            vec_t v = VECS[i];
            logic [63:0] e = model(v);
            int bc;
            bit ok;
            issue(v);
            wait_done(bc, ok);
            check(ok, "R7 done pulse seen", {63'd0, done}, 64'd1);
            // R1 R2 exact product
            check({res_hi, res_lo} == e, $sformatf("R1 R2 product vec %0d", i),
                  {res_hi, res_lo}, e);
            // R3 R4 R5 R6 latency
            check(cycles == v.ecyc, $sformatf("R3 R4 R5 R6 cycles vec %0d", i),
                  64'(cycles), 64'(v.ecyc));
            check(bc == int'(v.ecyc), $sformatf("R7 busy length vec %0d", i),
                  64'(bc), 64'(v.ecyc));
            if (v.fl) begin
                mn = (v.op >= 3'd2 && v.op <= 3'd5) ? e[63] : e[31];
                mz = (v.op >= 3'd2 && v.op <= 3'd5) ? (e == 0) : (e[31:0] == 0);
            end
            check(flag_n == mn && flag_z == mz, $sformatf("R5 flags vec %0d", i),
                  {62'd0, flag_n, flag_z}, {62'd0, mn, mz});
        end

        // R8: a start raised while busy must be ignored
        begin
            vec_t v = '{3'd0, 1'b0, 1'b0, 1'b0, 32'd2, 32'h800000, 32'd0, 32'd0, 4'd3};
            int bc;
            bit ok;
            logic [31:0] keep_lo;
            logic [3:0]  keep_c;
            issue(v);
            start = 1'b1; opa = 32'd5; opb = 32'd7; op = 3'd2;
            @(negedge clk);
            start = 1'b0;
            wait_done(bc, ok);
            check(ok && res_lo == 32'h1000000 && res_hi == 0, "R8 result unaffected",
                  {res_hi, res_lo}, 64'h1000000);
            check(cycles == 4'd3, "R8 cycles unaffected", 64'(cycles), 64'd3);
            keep_lo = res_lo; keep_c = cycles;
            @(negedge clk);
            check(!busy && !done, "R8 no extra operation", {62'd0, busy, done}, 64'd0);
            // R7 hold while idle
            repeat (3) @(negedge clk);
            check(res_lo == keep_lo && cycles == keep_c && !done, "R7 idle hold",
                  {28'd0, cycles, res_lo}, {28'd0, keep_c, keep_lo});
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule